// File: doc/BRIEF.md
# Telephone Line Hook and Ring Controller

This block is the digital control core for the DSP side of an isolated telephone line interface. It holds two small control registers, which software reaches through a synchronous write port and a combinational read port. From these registers and an active-low hook pin it forms the effective off-hook request. Software can request off-hook directly with a register bit. The pin takes part only when software has enabled it.

Once the line goes off-hook, the block counts sample periods, marked by a one-cycle strobe, and only then marks line data valid. That settling window already contains the filter group delay. The block also keeps a read-only ring flag. A ring pulse from the line side sets the flag. The flag clears when the line goes off-hook, or after a fixed idle time with no ring. A power-down bit holds the link across the barrier off. The link comes up only when software has cleared that bit and the sample clock reports a valid rate.

Top module: `hookring_ctrl`

## Requirements
- R1: The effective off-hook output `hook_active` is 1 when the hook-control register bit 0 (software hook) is 1, or when bit 1 (pin enable) is 1 and `hook_pin_n` is low.
- R2: When pin enable is 0, the level of `hook_pin_n` has no effect on `hook_active`.
- R3: `line_ready` goes to 1 only after exactly SETTLE_SAMPLES (default 4620) cycles with `fs_strobe` high while off-hook. This figure already includes the 12-sample group delay. Clock cycles without a strobe do not advance the count.
- R4: When off-hook drops, `line_ready` falls in the same cycle and the settle count restarts from zero. A new off-hook therefore needs the full count again.
- R5: A `ring_pulse` seen at a clock edge while on-hook sets `ring_flag` from the next cycle.
- R6: While off-hook, `ring_flag` is cleared at the next edge and held at 0, even when ring pulses arrive.
- R7: While on-hook, `ring_flag` clears exactly RING_TICKS×TICK_DIV clock cycles after the edge that saw the last ring pulse. The defaults give 12 half-second ticks, which is 6 s. Every new pulse restarts the timeout.
- R8: After reset, the link register bit 0 (power-down) is 1 and `link_en` is 0. Writing 1 to that bit disables the link from the next cycle.
- R9: `link_en` is 1 only while the power-down bit is 0 and `rate_valid` is 1.
- R10: Address 5 reads {3'b0, hook_active, line_ready, ring_flag, pin enable, software hook}. Address 6 reads {6'b0, link_en, power-down}. Other addresses read 0. Bits 4..2 at address 5 are read-only, and writes to them have no effect.
- R11: Reset clears software hook and pin enable, so `hook_active`, `line_ready` and `ring_flag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data (combinational from addr) |
| hook_pin_n | input | 1 | Active-low off-hook pin |
| fs_strobe | input | 1 | One-cycle pulse per sample period |
| ring_pulse | input | 1 | Ring detect pulse from the line side |
| rate_valid | input | 1 | Sample clock generator holds a valid rate |
| hook_active | output | 1 | Effective off-hook state |
| line_ready | output | 1 | Line data on the link is valid |
| ring_flag | output | 1 | Ring status flag |
| link_en | output | 1 | Cross-barrier link enabled |

## Verification
Assertions check the cycle-level rules on every cycle. A ring pulse seen while on-hook must set the flag. Off-hook must clear the flag. `line_ready` may only rise after a sample strobe, and the settle counter must never pass its limit. A write that sets power-down must drop the link, and a register write must never set the ring flag. Some timing can only be seen in the bench scenarios. These cover the exact 4620-strobe settling point, the exact 6-second timeout edge and its restart by a second ring, and the restart of settling after a hook drop. Random pin and register combinations check the hook decode.

// File: rtl/hookring_pkg.sv
package hookring_pkg;

    localparam int unsigned ADDR_W = 4;
    localparam int unsigned DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_HOOK = 4'd5;
    localparam logic [ADDR_W-1:0] ADDR_LINK = 4'd6;

    localparam int unsigned BIT_SWHOOK = 0;
    localparam int unsigned BIT_PINEN  = 1;
    localparam int unsigned BIT_RING   = 2;
    localparam int unsigned BIT_READY  = 3;
    localparam int unsigned BIT_HOOK   = 4;
    localparam int unsigned BIT_PDOWN  = 0;
    localparam int unsigned BIT_LINKON = 1;

    typedef struct packed {
        logic sw_hook;
        logic pin_en;
        logic pdown;
    } ctrl_t;

    typedef struct packed {
        logic hook;
        logic ready;
        logic ring;
        logic link;
    } stat_t;

    function automatic logic hook_request(input logic sw, input logic pin_en,
                                          input logic pin_n);
        return sw | (pin_en & ~pin_n);
    endfunction

    function automatic logic [DATA_W-1:0] pack_hook_reg(input ctrl_t c, input stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_SWHOOK] = c.sw_hook;
        v[BIT_PINEN]  = c.pin_en;
        v[BIT_RING]   = s.ring;
        v[BIT_READY]  = s.ready;
        v[BIT_HOOK]   = s.hook;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_link_reg(input ctrl_t c, input stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[BIT_PDOWN]  = c.pdown;
        v[BIT_LINKON] = s.link;
        return v;
    endfunction

endpackage

// File: rtl/hookring_regs.sv
module hookring_regs
    import hookring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.sw_hook <= 1'b0;
            ctrl_q.pin_en  <= 1'b0;
            ctrl_q.pdown   <= 1'b1;
        end else if (wr_en) begin
            if (addr == ADDR_HOOK) begin
                ctrl_q.sw_hook <= wr_data[BIT_SWHOOK];
                ctrl_q.pin_en  <= wr_data[BIT_PINEN];
            end
            if (addr == ADDR_LINK) begin
                ctrl_q.pdown <= wr_data[BIT_PDOWN];
            end
        end
    end

    assign ctrl = ctrl_q;

    AST_PDOWN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_LINK && wr_data[BIT_PDOWN]) |=> ctrl_q.pdown); // R8

endmodule

// File: rtl/hookring_settle.sv
module hookring_settle #(
    parameter int unsigned SETTLE_SAMPLES = 4620
) (
    input  logic clk,
    input  logic rst,
    input  logic hook_in,
    input  logic fs_strobe,
    output logic ready
);

    localparam int unsigned CNT_W = $clog2(SETTLE_SAMPLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_SAMPLES);

    logic [CNT_W-1:0] cnt_q;
    logic             done;

    assign done = (cnt_q == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !hook_in) begin
            cnt_q <= '0;
        end else if (fs_strobe && !done) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ready = hook_in & done;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LAST); // R3
    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(ready) |-> $past(fs_strobe)); // R3
    AST_DROP_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        !hook_in |=> (cnt_q == '0)); // R4

endmodule

// File: rtl/hookring_ring.sv
module hookring_ring #(
    parameter int unsigned TICK_DIV   = 50_000_000,
    parameter int unsigned RING_TICKS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic hook_in,
    input  logic ring_pulse,
    output logic flag
);

    localparam int unsigned PRE_W  = $clog2(TICK_DIV + 1);
    localparam int unsigned TICK_W = $clog2(RING_TICKS + 1);
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(TICK_DIV - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(RING_TICKS - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [TICK_W-1:0] ticks_q;
    logic              flag_q;
    logic              tick;

    assign tick = (pre_q == PRE_LAST);

    always_ff @(posedge clk) begin
        if (rst || hook_in) begin
            flag_q  <= 1'b0;
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (ring_pulse) begin
            flag_q  <= 1'b1;
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (flag_q) begin
            pre_q <= tick ? '0 : pre_q + 1'b1;
            if (tick) begin
                if (ticks_q == TICK_LAST) begin
                    flag_q  <= 1'b0;
                    ticks_q <= '0;
                end else begin
                    ticks_q <= ticks_q + 1'b1;
                end
            end
        end
    end

    assign flag = flag_q;

    AST_RING_SETS: assert property (@(posedge clk) disable iff (rst)
        (ring_pulse && !hook_in) |=> flag_q); // R5
    AST_HOOK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        hook_in |=> !flag_q); // R6
    AST_TICK_BOUND: assert property (@(posedge clk) disable iff (rst)
        ticks_q <= TICK_LAST); // R7

endmodule

// File: rtl/hookring_ctrl.sv
module hookring_ctrl
    import hookring_pkg::*;
#(
    parameter int unsigned SETTLE_SAMPLES = 4620,
    parameter int unsigned TICK_DIV       = 50_000_000,
    parameter int unsigned RING_TICKS     = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [3:0]  addr,
    input  logic [7:0]  wr_data,
    output logic [7:0]  rd_data,
    input  logic        hook_pin_n,
    input  logic        fs_strobe,
    input  logic        ring_pulse,
    input  logic        rate_valid,
    output logic        hook_active,
    output logic        line_ready,
    output logic        ring_flag,
    output logic        link_en
);

    ctrl_t ctrl;
    stat_t stat;

    hookring_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    assign stat.hook = hook_request(ctrl.sw_hook, ctrl.pin_en, hook_pin_n);
    assign stat.link = ~ctrl.pdown & rate_valid;

    hookring_settle #(
        .SETTLE_SAMPLES (SETTLE_SAMPLES)
    ) u_settle (
        .clk       (clk),
        .rst       (rst),
        .hook_in   (stat.hook),
        .fs_strobe (fs_strobe),
        .ready     (stat.ready)
    );

    hookring_ring #(
        .TICK_DIV   (TICK_DIV),
        .RING_TICKS (RING_TICKS)
    ) u_ring (
        .clk        (clk),
        .rst        (rst),
        .hook_in    (stat.hook),
        .ring_pulse (ring_pulse),
        .flag       (stat.ring)
    );

    always_comb begin
        case (addr)
            ADDR_HOOK: rd_data = pack_hook_reg(ctrl, stat);
            ADDR_LINK: rd_data = pack_link_reg(ctrl, stat);
            default:   rd_data = '0;
        endcase
    end

    assign hook_active = stat.hook;
    assign line_ready  = stat.ready;
    assign ring_flag   = stat.ring;
    assign link_en     = stat.link;

    AST_RDT_READONLY: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_HOOK && !ring_pulse && !ring_flag) |=> !ring_flag); // R10
    AST_LINK_OFF_ON_PDOWN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == ADDR_LINK && wr_data[BIT_PDOWN]) |=> !link_en); // R8
    AST_LINK_NEEDS_RATE: assert property (@(posedge clk) disable iff (rst)
        link_en |-> rate_valid); // R9

endmodule

// File: tb/hookring_ctrl_tb_top.sv
`timescale 1ns/1ps
module hookring_ctrl_tb_top;

    localparam int unsigned SETTLE = 4620;
    localparam int unsigned TDIV   = 16;
    localparam int unsigned RTICKS = 12;
    localparam int unsigned TMO    = TDIV * RTICKS;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       hook_pin_n = 1'b1;
    logic       fs_strobe = 1'b0;
    logic       ring_pulse = 1'b0;
    logic       rate_valid = 1'b0;
    logic       hook_active, line_ready, ring_flag, link_en;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hookring_ctrl #(
        .SETTLE_SAMPLES (SETTLE),
        .TICK_DIV       (TDIV),
        .RING_TICKS     (RTICKS)
    ) dut_i (
        .clk (clk), .rst (rst), .wr_en (wr_en), .addr (addr),
        .wr_data (wr_data), .rd_data (rd_data), .hook_pin_n (hook_pin_n),
        .fs_strobe (fs_strobe), .ring_pulse (ring_pulse), .rate_valid (rate_valid),
        .hook_active (hook_active), .line_ready (line_ready),
        .ring_flag (ring_flag), .link_en (link_en)
    );

    function automatic logic exp_hook(input logic sw, input logic pe, input logic pin_n);
        return sw | (pe & ~pin_n);
    endfunction

    function automatic logic [7:0] exp_hook_reg(input logic sw, input logic pe,
        input logic ring, input logic rdy, input logic hk);
        return {3'b000, hk, rdy, ring, pe, sw};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        addr = a;
        #0.5;
        d = rd_data;
    endtask

    task automatic ring_once();
        ring_pulse = 1'b1;
        @(negedge clk);
        ring_pulse = 1'b0;
    endtask

    task automatic strobes(input int n);
        for (int i = 0; i < n; i++) begin
            fs_strobe = 1'b1;
            @(negedge clk);
            fs_strobe = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        logic sw, pe, pin, extra;
        void'($urandom(32'd1789));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 / R8 reset state
        rd(4'd5, d); check("R11 hook reg reset", d, 8'h00);
        rd(4'd6, d); check("R8 link reg reset", d, 8'h01);
        check("R8 link_en at reset", link_en, 1'b0);
        check("R11 hook_active at reset", hook_active, 1'b0);

        // R9 link gating
        wr(4'd6, 8'h00);
        check("R9 link off without rate", link_en, 1'b0);
        rate_valid = 1'b1; #0.5;
        check("R9 link on with rate and pdown clear", link_en, 1'b1);
        rd(4'd6, d); check("R10 link reg read", d, 8'h02);
        rd(4'd3, d); check("R10 unmapped reads zero", d, 8'h00);

        // R1 / R2 / R10 random hook decode; upper bits are random and read-only
        for (int k = 0; k < 40; k++) begin
            sw = 1'($urandom); pe = 1'($urandom); pin = 1'($urandom);
            extra = 1'($urandom);
            hook_pin_n = pin;
            wr(4'd5, {3'b000, extra, extra, extra, pe, sw});
            check(pe ? "R1 hook decode" : "R2 pin ignored when disabled",
                  hook_active, exp_hook(sw, pe, pin));
            rd(4'd5, d);
            check("R10 hook reg bits", {d[7:5], d[2:0]},
                  {3'b000, 1'b0, pe, sw});
            wr(4'd5, 8'h00);
        end
        // R2 directed: pin low, pin disabled
        hook_pin_n = 1'b0; #0.5;
        check("R2 pin low ignored", hook_active, 1'b0);
        hook_pin_n = 1'b1;
        @(negedge clk);

        // R5 / R7 timeout edge
        ring_once();
        check("R5 ring sets flag", ring_flag, 1'b1);
        wr(4'd5, 8'h04);
        rd(4'd5, d); check("R10 write to RDT ignored", d[2], 1'b1);
        repeat (TMO - 2) @(negedge clk);
        check("R7 flag held before timeout", ring_flag, 1'b1);
        @(negedge clk);
        check("R7 flag clears at timeout", ring_flag, 1'b0);
        wr(4'd5, 8'h04);
        rd(4'd5, d); check("R10 RDT write cannot set flag", d[2], 1'b0);

        // R7 restart by second ring
        ring_once();
        repeat (100) @(negedge clk);
        ring_once();
        repeat (TMO - 1) @(negedge clk);
        check("R7 restarted timeout still high", ring_flag, 1'b1);
        @(negedge clk);
        check("R7 restarted timeout clears", ring_flag, 1'b0);

        // R6 off-hook clears flag, blocks new rings
        ring_once();
        check("R6 precondition flag set", ring_flag, 1'b1);
        wr(4'd5, 8'h02);
        hook_pin_n = 1'b0;
        @(negedge clk);
        check("R6 off-hook via pin clears flag", ring_flag, 1'b0);
        ring_once();
        check("R6 ring ignored while off-hook", ring_flag, 1'b0);
        hook_pin_n = 1'b1;
        wr(4'd5, 8'h00);

        // R3 settling
        wr(4'd5, 8'h01);
        strobes(SETTLE - 1);
        check("R3 not ready one strobe short", line_ready, 1'b0);
        repeat (50) @(negedge clk);
        check("R3 idle cycles do not count", line_ready, 1'b0);
        strobes(1);
        check("R3 ready after full count", line_ready, 1'b1);
        rd(4'd5, d); check("R10 hook reg while ready", d, exp_hook_reg(1, 0, 0, 1, 1));

        // R4 drop and restart
        wr(4'd5, 8'h00);
        check("R4 ready drops with hook", line_ready, 1'b0);
        wr(4'd5, 8'h01);
        strobes(1);
        check("R4 count restarted", line_ready, 1'b0);
        strobes(SETTLE - 2);
        check("R4 still short after restart", line_ready, 1'b0);
        strobes(1);
        check("R4 ready after full recount", line_ready, 1'b1);

        // R8 / R9 power-down again, rate loss
        wr(4'd6, 8'h01);
        check("R8 pdown write disables link", link_en, 1'b0);
        wr(4'd6, 8'h00);
        check("R9 link back on", link_en, 1'b1);
        rate_valid = 1'b0; #0.5;
        check("R9 rate loss disables link", link_en, 1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule